// File: doc/BRIEF.md
# CSR Transaction Sequencer

This block is the initiating side of a select-addressed CSR bus. It takes one command from a local user (read or write, target select, address, write data) and runs it to completion over a three-signal handshake. The sequencer raises a request strobe. It keeps the strobe up until a target acknowledges, then drops it. It waits for the acknowledge to go away. For a read it then waits for the read-data strobe to rise and to fall again. Only after that does it return the result.

Completion is keyed to the falling edge of each target pulse, not the rising edge. A target clocked from a slower derived clock may therefore hold its acknowledge or read-data strobe for many sequencer cycles. A new transaction cannot begin while the target is still mid-pulse. An optional cycle limit on the request phase ends a transaction that no target answers, and reports it with an error flag.

The command port is valid/ready. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole life of a transaction. A command held on the port during that time waits and is not queued. The result port has no back-pressure: `done` is a single-cycle pulse, and the result fields are valid in that cycle.

Top module: `csr_seq_master`

## Requirements
- R1: While `rst_n` is low and after its release, `bus_valid`, `busy` and `done` are low and `cmd_ready` is high.
- R2: A command is accepted on an edge with `cmd_valid` and `cmd_ready` high. From the next cycle `bus_valid` is high, and `bus_write` (1 = write), `bus_sel`, `bus_addr` and `bus_wdata` carry the command fields.
- R3: `bus_valid` stays high until `bus_ack` is sampled high, and is low in the cycle after that sample.
- R4: A write completes only after `bus_ack` has been sampled low following its high phase. `done` rises in the cycle after that low sample, however long the acknowledge lasted.
- R5: A read completes only after `bus_rdv` has been sampled high and then low after the acknowledge. `done` rises in the cycle after the low sample, whatever gap precedes the strobe and however long it lasts.
- R6: For a read, `done_rdata` equals `bus_rdata` as sampled on the first edge at which `bus_rdv` is high. Later changes of `bus_rdata` while the strobe is still high have no effect on it.
- R7: `done` is high for exactly one cycle per transaction. `busy` is high from the cycle after acceptance through the `done` cycle. `cmd_ready` is the inverse of `busy`.
- R8: While `busy` is high, `cmd_valid` is ignored. The bus fields stay unchanged, and no extra transaction follows.
- R9: With `TIMEOUT_CYC` nonzero, if no acknowledge arrives, `bus_valid` is high for exactly `TIMEOUT_CYC` cycles. The transaction then ends with `done` and `done_err` high.
- R10: `done_err` is low for every transaction that was acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_sel | input | SEL_W | Target select |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a timeout |
| done_rdata | output | DATA_W | Captured read data |
| bus_valid | output | 1 | Request strobe to targets |
| bus_write | output | 1 | Request direction |
| bus_sel | output | SEL_W | Request select |
| bus_addr | output | ADDR_W | Request address |
| bus_wdata | output | DATA_W | Request write data |
| bus_ack | input | 1 | Target acknowledge |
| bus_rdv | input | 1 | Target read-data strobe |
| bus_rdata | input | DATA_W | Target read data |

## Verification
Several properties are checked on every cycle:
- the request strobe is held until an acknowledge and dropped right after it;
- `done` is a single pulse, and `cmd_ready` mirrors `busy`;
- the bus fields stay stable during a transaction, and the captured read data changes only at its capture;
- a write never completes while the acknowledge is still high, and the timeout counter stays within range.

Other behaviour only the bench scenarios can show: completion waits for the trailing edge of long acknowledge and read-data pulses, the data captured is the value at the first strobe cycle, commands offered while busy are ignored, and an unanswered select times out after exactly the configured count.

// File: rtl/csr_seq_pkg.sv
package csr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_ACK_LO = 3'd2,
    ST_RDV_HI = 3'd3,
    ST_RDV_LO = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/csr_seq_timer.sv
module csr_seq_timer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  generate
    if (TIMEOUT_CYC == 0) begin : g_off
      assign expired = 1'b0;
    end else begin : g_on
      localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end

      assign expired = run && (cnt_q == LAST);

      // R9: the counter never passes its limit
      p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/csr_seq_cmdreg.sv
module csr_seq_cmdreg #(
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_write,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              q_write,
  output logic [SEL_W-1:0]  q_sel,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_sel   <= '0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (load) begin
      q_write <= in_write;
      q_sel   <= in_sel;
      q_addr  <= in_addr;
      q_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/csr_seq_rdcap.sv
module csr_seq_rdcap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= rdata_in;
  end

  // R6: held data moves only on a capture
  p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rdata_q));
endmodule

// File: rtl/csr_seq_fsm.sv
module csr_seq_fsm
  import csr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic is_write,
  input  logic bus_ack,
  input  logic bus_rdv,
  input  logic tmo_expired,
  output logic accept,
  output logic in_req,
  output logic cap_en,
  output logic cmd_ready,
  output logic busy,
  output logic done,
  output logic done_err
);
  seq_state_e st_q, st_d;
  logic err_q, err_d;

  always_comb begin
    st_d   = st_q;
    err_d  = err_q;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          st_d  = ST_REQ;
          err_d = 1'b0;
        end
      end
      ST_REQ: begin
        if (bus_ack) st_d = ST_ACK_LO;
        else if (tmo_expired) begin
          st_d  = ST_DONE;
          err_d = 1'b1;
        end
      end
      ST_ACK_LO: begin
        if (!bus_ack) begin
          if (is_write) st_d = ST_DONE;
          else if (bus_rdv) begin
            cap_en = 1'b1;
            st_d   = ST_RDV_LO;
          end else st_d = ST_RDV_HI;
        end
      end
      ST_RDV_HI: begin
        if (bus_rdv) begin
          cap_en = 1'b1;
          st_d   = ST_RDV_LO;
        end
      end
      ST_RDV_LO: begin
        if (!bus_rdv) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign in_req    = (st_q == ST_REQ);
  assign done      = (st_q == ST_DONE);
  assign done_err  = done && err_q;

  // R3: request held while unanswered and not timed out
  p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_req && !bus_ack && !tmo_expired |=> in_req);
  // R3: request dropped after acknowledge
  p_valid_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_req && bus_ack |=> !in_req);
  // R4: write never finishes while acknowledge was still high
  p_wr_after_ack_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_err && is_write |-> !$past(bus_ack));
  // R5: read finishes only after the data strobe was seen low
  p_rd_after_rdv_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_err && !is_write |-> !$past(bus_rdv));
  // R7: single-cycle completion
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: ready is the inverse of busy
  p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready != busy);
endmodule

// File: rtl/csr_seq_master.sv
module csr_seq_master #(
  parameter int SEL_W       = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic [DATA_W-1:0] done_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_rdv,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic accept, in_req, cap_en, tmo_expired;

  csr_seq_cmdreg #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmdreg (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .in_write(cmd_write), .in_sel(cmd_sel), .in_addr(cmd_addr), .in_wdata(cmd_wdata),
    .q_write(bus_write), .q_sel(bus_sel), .q_addr(bus_addr), .q_wdata(bus_wdata)
  );

  csr_seq_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_req), .expired(tmo_expired)
  );

  csr_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .is_write(bus_write),
    .bus_ack(bus_ack), .bus_rdv(bus_rdv), .tmo_expired(tmo_expired),
    .accept(accept), .in_req(in_req), .cap_en(cap_en),
    .cmd_ready(cmd_ready), .busy(busy), .done(done), .done_err(done_err)
  );

  csr_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .rdata_in(bus_rdata), .rdata_q(done_rdata)
  );

  assign bus_valid = in_req;

  // R8: request fields frozen while a transaction runs
  p_fields_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(bus_addr) && $stable(bus_sel) && $stable(bus_write));
  // R10: no error flag on an acknowledged request
  p_no_err_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ack |=> !done_err);
endmodule

// File: tb/csr_seq_master_tb_top.sv
module csr_seq_master_tb_top;
  localparam int SEL_W = 4, ADDR_W = 16, DATA_W = 32, TMO = 16;
  localparam logic [SEL_W-1:0] T_SEL = 4'h5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [SEL_W-1:0]  cmd_sel = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic              cmd_ready, busy, done, done_err;
  logic [DATA_W-1:0] done_rdata;
  logic              bus_valid, bus_write;
  logic [SEL_W-1:0]  bus_sel;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_ack = 1'b0, bus_rdv = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;

  csr_seq_master #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .done_err(done_err), .done_rdata(done_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdv(bus_rdv), .bus_rdata(bus_rdata)
  );

  typedef struct { logic wr; logic err; logic [DATA_W-1:0] rdata; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  int t_delay = 0, t_len = 1, t_gap = 0;
  logic [DATA_W-1:0] t_rdata = '0;
  bit txn_complete = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // target model: responds to T_SEL only
  task automatic target_loop();
    logic wr;
    forever begin
      @(negedge clk);
      if (bus_valid) begin
        if (bus_sel == T_SEL) begin
          wr = bus_write;
          for (int i = 0; i < t_delay; i++) begin
            check(bus_valid === 1'b1, "R3 valid held before ack", bus_valid, 1);
            @(negedge clk);
          end
          bus_ack = 1'b1;
          for (int i = 0; i < t_len; i++) @(negedge clk);
          check(bus_valid === 1'b0, "R3 valid dropped after ack", bus_valid, 0);
          bus_ack = 1'b0;
          if (!wr) begin
            for (int i = 0; i < t_gap; i++) @(negedge clk);
            bus_rdv = 1'b1;
            bus_rdata = t_rdata;
            @(negedge clk);
            bus_rdata = ~t_rdata;
            for (int i = 0; i < t_len - 1; i++) @(negedge clk);
            bus_rdv = 1'b0;
            bus_rdata = '0;
          end
          txn_complete = 1;
        end else begin
          while (bus_valid) @(negedge clk);
        end
      end
    end
  endtask

  // monitor / scoreboard
  task automatic monitor_loop();
    exp_t e;
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected completion", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(done_err === e.err, e.err ? "R9 error flag" : "R10 no error", done_err, e.err);
          if (!e.err) check(txn_complete == 1, e.wr ? "R4 write done after ack low" : "R5 read done after rdv low",
                            txn_complete, 1);
          if (!e.wr && !e.err) check(done_rdata === e.rdata, "R6 read data", done_rdata, e.rdata);
          check(bus_valid === 1'b0 && busy === 1'b1, "R7 busy during done", busy, 1);
          @(negedge clk);
          check(done === 1'b0 && busy === 1'b0 && cmd_ready === 1'b1, "R7 done one cycle", {done, busy}, 0);
        end
      end
    end
  endtask

  task automatic issue(input logic wr, input logic [SEL_W-1:0] sel, input logic [ADDR_W-1:0] addr,
                       input logic [DATA_W-1:0] wd, input bit err, input bit spam);
    exp_t e;
    int vcnt;
    e.wr = wr; e.err = err; e.rdata = t_rdata;
    exp_q.push_back(e);
    txn_complete = 0;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_sel = sel; cmd_addr = addr; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(bus_valid === 1'b1 && bus_addr === addr && bus_sel === sel && bus_write === wr &&
          bus_wdata === wd, "R2 fields on bus", bus_addr, addr);
    check(busy === 1'b1 && cmd_ready === 1'b0, "R7 busy after accept", busy, 1);
    if (spam) begin
      cmd_valid = 1'b1; cmd_addr = ~addr; cmd_write = ~wr;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check(bus_addr === addr && bus_write === wr, "R8 busy command ignored", bus_addr, addr);
      end
      cmd_valid = 1'b0;
    end
    if (err) begin
      vcnt = 0;
      while (bus_valid) begin vcnt++; @(negedge clk); end
      check(vcnt == TMO, "R9 timeout length", vcnt, TMO);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    if (spam) check(busy === 1'b0 && bus_valid === 1'b0, "R8 no extra transaction", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && cmd_ready === 1'b1,
          "R1 reset state", {bus_valid, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_valid === 1'b0 && busy === 1'b0 && cmd_ready === 1'b1, "R1 after release", busy, 0);
    fork target_loop(); monitor_loop(); join_none

    // same-rate target, write then read
    t_delay = 0; t_len = 1; t_gap = 0; t_rdata = 32'hA5A5_0001;
    issue(1'b1, T_SEL, 16'h0010, 32'h1234_5678, 0, 0);
    issue(1'b0, T_SEL, 16'h0014, 32'h0, 0, 0);
    // slow target: long pulses, delayed ack, gap before read data
    t_delay = 3; t_len = 5; t_gap = 2; t_rdata = 32'hDEAD_BEEF;
    issue(1'b1, T_SEL, 16'h0100, 32'hCAFE_F00D, 0, 0);
    issue(1'b0, T_SEL, 16'h0104, 32'h0, 0, 0);
    // long strobe with no gap, data changes during strobe
    t_delay = 1; t_len = 4; t_gap = 0; t_rdata = 32'h0BAD_C0DE;
    issue(1'b0, T_SEL, 16'h0200, 32'h0, 0, 0);
    // commands offered while busy
    t_delay = 6; t_len = 2; t_gap = 1; t_rdata = 32'h1357_9BDF;
    issue(1'b0, T_SEL, 16'h0300, 32'h0, 0, 1);
    issue(1'b1, T_SEL, 16'h0304, 32'h7777_0000, 0, 1);
    // unanswered select: timeout
    issue(1'b0, 4'h9, 16'h0400, 32'h0, 1, 0);
    // recovery after timeout
    t_delay = 0; t_len = 1; t_gap = 0; t_rdata = 32'h2468_ACE0;
    issue(1'b0, T_SEL, 16'h0500, 32'h0, 0, 0);
    finish_run();
  end
endmodule